// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one byte-wide bidirectional I/O port. Software sets each pin as input or output through a direction register. It writes output values into a latch and reads back either the latch or the pin levels. The pin levels pass through a two-flop synchronizer before they can be read. The block drives pad-control signals only: drive enable, output value and weak pull-up enable for each pin. The pads themselves are outside it.

Three overrides sit on top of the normal direction and latch control, in fixed priority:

1. An external-bus mode hands the whole byte to a multiplexed address/data bus and ignores the direction register.
2. A parallel-slave-port mode takes the three lowest pins as control inputs and brings out their synchronized levels.
3. A peripheral output can be routed onto the top pin, with an optional open-drain behaviour.

A single global bit enables the weak pull-ups. A pull-up is never active on a pin that is configured as an output.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the direction register reads 0xFF, the latch reads 0x00 and the control register reads 0x04. In that state every pad enable and every pull-up output is 0.
- R2: Direction bit 1 makes the pin an input, so its drive enable is 0. Direction bit 0 makes the pin drive its latch bit on the pad output. Direction is written and read at address 2.
- R3: A write to address 0 or to address 1 updates the latch. A read of address 1 returns the latch.
- R4: A read of address 0 returns the pad inputs delayed by two rising clock edges. After only one edge, the read still shows the previous value.
- R5: Control bit 0 is the global pull-up enable. Outside bus mode, a pin's pull-up output is 1 exactly when that bit is 1 and the pin's direction bit is 1.
- R6: When the peripheral is active on pin 7 and control bit 1 (open-drain) is 0, pin 7 drives the peripheral's value. When control bit 1 is 1, pin 7 drives low for a peripheral 0 and releases the pin (drive enable 0) for a peripheral 1. Both cases require direction bit 7 to be 0.
- R7: While parallel-slave-port mode is on, pins 0 to 2 have drive enable 0 whatever their direction bits say. The parallel-slave-port control output then carries the synchronized levels of pins 0 to 2. While the mode is off, that output is 0.
- R8: Control bit 2 is the bus-disable bit and resets to 1. When it is 0, every pin's drive enable follows the bus drive enable and every pad output follows the bus data. All pull-ups are then 0, and the direction register has no effect.
- R9: Bus mode takes priority over the parallel-slave-port and peripheral overrides. The parallel-slave-port override takes priority over the peripheral override.
- R10: Control bits 7 to 3 read as 0. The synchronized pad byte is always available on the bus input output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 port, 1 latch, 2 direction, 3 control) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, same cycle |
| pad_in_i | input | 8 | Pin levels from the pads |
| pad_oe_o | output | 8 | Per-pin drive enable |
| pad_out_o | output | 8 | Per-pin output value |
| pad_pu_o | output | 8 | Per-pin weak pull-up enable |
| psp_en_i | input | 1 | Parallel-slave-port mode active |
| psp_ctl_o | output | 3 | Synchronized control inputs from pins 0 to 2 |
| periph_act_i | input | 1 | Peripheral routed onto pin 7 |
| periph_out_i | input | 1 | Peripheral output value |
| bus_oe_i | input | 1 | External bus drive enable |
| bus_out_i | input | 8 | External bus high-byte output |
| bus_in_o | output | 8 | Synchronized pad byte for the bus |

## Verification
Most register state is visible at the pads in the same cycle it changes. A wrong direction, latch or control bit therefore shows on pad_oe_o, pad_out_o or pad_pu_o right after the write edge, and it also reads back at once through rdata_o. Faults in the synchronizer appear only on reads of address 0 or on psp_ctl_o. They become visible two edges after a pad change, so the bench samples both after one edge and after two. An override decoded in the wrong priority shows only when two modes are active at the same time, so those combinations are driven on purpose.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ADDR_PORT = 2'd0,
    ADDR_LAT  = 2'd1,
    ADDR_DIR  = 2'd2,
    ADDR_CTRL = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic bus_off;
    logic od_en;
    logic pu_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{bus_off: 1'b1, od_en: 1'b0, pu_en: 1'b0};
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_sync_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lat_o,
  output ctrl_t        ctrl_o
);
  localparam int CW = $bits(ctrl_t);

  reg_addr_e addr;
  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '1;
      lat_o  <= '0;
      ctrl_o <= CTRL_RST;
    end else if (wr_en_i) begin
      unique case (addr)
        ADDR_PORT, ADDR_LAT: lat_o  <= wdata_i;
        ADDR_DIR:            dir_o  <= wdata_i;
        ADDR_CTRL:           ctrl_o <= ctrl_t'(wdata_i[CW-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      ADDR_PORT: rdata_o = pin_sync_i;
      ADDR_LAT:  rdata_o = lat_o;
      ADDR_DIR:  rdata_o = dir_o;
      ADDR_CTRL: rdata_o[CW-1:0] = ctrl_o;
      default: ;
    endcase
  end

  // R3: both port and latch addresses load the latch
  a_r3_lat_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == ADDR_PORT || addr_i == ADDR_LAT)) |=> (lat_o == $past(wdata_i)));

  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_DIR) |=> (dir_o == $past(wdata_i)));

  a_r2_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_DIR) |=> $stable(dir_o));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W        = 8,
  parameter int PSP_PINS = 3,
  parameter int OD_PIN   = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic         pu_en_i,
  input  logic         od_en_i,
  input  logic         bus_on_i,
  input  logic         bus_oe_i,
  input  logic [W-1:0] bus_out_i,
  input  logic         psp_en_i,
  input  logic         periph_act_i,
  input  logic         periph_out_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam bit IS_PSP = (i < PSP_PINS);
    localparam bit IS_OD  = (i == OD_PIN);

    always_comb begin
      oe_o[i]  = ~dir_i[i];
      out_o[i] = lat_i[i];
      pu_o[i]  = pu_en_i & dir_i[i];
      if (bus_on_i) begin
        oe_o[i]  = bus_oe_i;
        out_o[i] = bus_out_i[i];
        pu_o[i]  = 1'b0;
      end else if (IS_PSP && psp_en_i) begin
        oe_o[i] = 1'b0;
      end else if (IS_OD && periph_act_i) begin
        if (od_en_i) begin
          oe_o[i]  = ~dir_i[i] & ~periph_out_i;
          out_o[i] = 1'b0;
        end else begin
          out_o[i] = periph_out_i;
        end
      end
    end
  end

  // R5: pull-up never on a pin configured as output
  a_r5_pu_only_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & ~dir_i) == '0);

  a_r8_bus_owns_pads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_on_i |-> (oe_o == {W{bus_oe_i}} && out_o == bus_out_i && pu_o == '0));

  a_r7_psp_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_on_i && psp_en_i) |-> (oe_o[PSP_PINS-1:0] == '0));

  a_r6_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_on_i && periph_act_i && od_en_i) |-> !(oe_o[OD_PIN] && out_o[OD_PIN]));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int W        = 8,
  parameter int PSP_PINS = 3,
  parameter int OD_PIN   = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [W-1:0]        wdata_i,
  output logic [W-1:0]        rdata_o,
  input  logic [W-1:0]        pad_in_i,
  output logic [W-1:0]        pad_oe_o,
  output logic [W-1:0]        pad_out_o,
  output logic [W-1:0]        pad_pu_o,
  input  logic                psp_en_i,
  output logic [PSP_PINS-1:0] psp_ctl_o,
  input  logic                periph_act_i,
  input  logic                periph_out_i,
  input  logic                bus_oe_i,
  input  logic [W-1:0]        bus_out_i,
  output logic [W-1:0]        bus_in_o
);
  logic [W-1:0] pin_sync, dir, lat;
  ctrl_t        ctrl;

  gpio_sync #(.W(W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .pin_sync_i(pin_sync), .rdata_o(rdata_o),
    .dir_o(dir), .lat_o(lat), .ctrl_o(ctrl)
  );

  gpio_pad_mux #(.W(W), .PSP_PINS(PSP_PINS), .OD_PIN(OD_PIN)) u_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir), .lat_i(lat),
    .pu_en_i(ctrl.pu_en), .od_en_i(ctrl.od_en), .bus_on_i(~ctrl.bus_off),
    .bus_oe_i(bus_oe_i), .bus_out_i(bus_out_i), .psp_en_i(psp_en_i),
    .periph_act_i(periph_act_i), .periph_out_i(periph_out_i),
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o)
  );

  assign psp_ctl_o = psp_en_i ? pin_sync[PSP_PINS-1:0] : '0;
  assign bus_in_o  = pin_sync;

  // R7: control lines quiet when the mode is off
  a_r7_psp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psp_en_i |-> (psp_ctl_o == '0));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_ni = 0;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pad_in = 0, bus_out = 0;
  logic       psp_en = 0, periph_act = 0, periph_out = 0, bus_oe = 0;
  logic [7:0] rdata, pad_oe, pad_out, pad_pu, bus_in;
  logic [2:0] psp_ctl;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_oe_o(pad_oe), .pad_out_o(pad_out), .pad_pu_o(pad_pu),
    .psp_en_i(psp_en), .psp_ctl_o(psp_ctl), .periph_act_i(periph_act),
    .periph_out_i(periph_out), .bus_oe_i(bus_oe), .bus_out_i(bus_out),
    .bus_in_o(bus_in)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2, v); chk("R1 dir", v, 8'hFF);
    rd(1, v); chk("R1 lat", v, 8'h00);
    rd(3, v); chk("R1 ctrl", v, 8'h04);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 pu", pad_pu, 8'h00);
  endtask

  task automatic t_dir_latch();
    logic [7:0] v;
    wr(2, 8'h03); wr(1, 8'hA5);
    chk("R2 oe", pad_oe, 8'hFC);
    chk("R2 out", pad_out, 8'hA5);
    rd(2, v); chk("R2 dir read", v, 8'h03);
    wr(0, 8'h3C);
    rd(1, v); chk("R3 port addr write", v, 8'h3C);
    chk("R3 pad out", pad_out, 8'h3C);
    wr(1, 8'h00);
    rd(1, v); chk("R3 lat clear", v, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    @(negedge clk); pad_in = 8'h5A;
    @(negedge clk); rd(0, v); chk("R4 one edge", v, 8'h00);
    @(negedge clk); rd(0, v); chk("R4 two edges", v, 8'h5A);
    chk("R10 bus_in", bus_in, 8'h5A);
  endtask

  task automatic t_pullup();
    logic [7:0] v;
    wr(3, 8'hFD);
    rd(3, v); chk("R10 ctrl upper zero", v, 8'h05);
    chk("R5 pu gated", pad_pu, 8'h03);
    wr(2, 8'hF0);
    chk("R5 pu follows dir", pad_pu, 8'hF0);
    wr(3, 8'h04);
    chk("R5 pu off", pad_pu, 8'h00);
  endtask

  task automatic t_periph();
    wr(2, 8'h00); wr(1, 8'h00);
    @(negedge clk); periph_act = 1; periph_out = 1; #1;
    chk("R6 push oe", pad_oe[7], 1'b1);
    chk("R6 push out", pad_out[7], 1'b1);
    wr(3, 8'h06);
    periph_out = 0; #1;
    chk("R6 od low oe", pad_oe[7], 1'b1);
    chk("R6 od low out", pad_out[7], 1'b0);
    periph_out = 1; #1;
    chk("R6 od release", pad_oe[7], 1'b0);
  endtask

  task automatic t_psp();
    @(negedge clk); psp_en = 1; pad_in = 8'h05; #1;
    chk("R7 oe forced", pad_oe, 8'h78);
    @(negedge clk); @(negedge clk);
    chk("R7 ctl", psp_ctl, 8'h05);
    psp_en = 0; #1;
    chk("R7 ctl off", psp_ctl, 8'h00);
  endtask

  task automatic t_bus();
    logic [7:0] v;
    @(negedge clk); psp_en = 1; bus_oe = 1; bus_out = 8'h9C;
    wr(2, 8'hFF);
    wr(3, 8'h03);
    chk("R8 oe", pad_oe, 8'hFF);
    chk("R8 out", pad_out, 8'h9C);
    chk("R8 pu", pad_pu, 8'h00);
    bus_oe = 0; #1;
    chk("R9 bus over psp/periph", pad_oe, 8'h00);
    wr(2, 8'h00);
    chk("R8 dir ignored", pad_oe, 8'h00);
    rd(2, v); chk("R8 dir still stored", v, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_dir_latch();
    t_sync();
    t_pullup();
    t_periph();
    t_psp();
    t_bus();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule